// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It holds two direction predictors side by side. One keeps a short outcome history for each branch slot and uses that history to pick a two-bit counter. The other keeps one shared history of the most recent outcomes of all branches and uses it to pick a counter of its own. A third table of two-bit counters, selected by the branch address, decides which of the two guesses becomes the output. The prediction is combinational: it is read from the current table state for the address on the lookup port in the same cycle.

When a branch resolves, the pipeline presents the branch address and its real outcome on the resolve port for one cycle. On that clock edge both pattern counters step toward the real outcome. The outcome is shifted into the branch's own history and into the shared history. If exactly one of the two components was right, the chooser counter steps toward it. A lookup in the same cycle as a resolve sees the state from before the update. All tables are small and direct-mapped, so every state change can be predicted exactly.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every pattern counter is 1 (weakly not taken), every history is zero and every chooser counter is 1 (weakly favouring the per-branch predictor), so every lookup predicts not taken.
- R2: The table slot for an address is taken from address bits [4:2]. Other address bits have no effect, so two addresses that share bits [4:2] share every per-branch entry and get the same prediction.
- R3: Every counter is 2 bits wide and saturates at 0 and 3. The values 2 and 3 mean taken, and 0 and 1 mean not taken.
- R4: Each slot keeps a 3-bit history. A resolve shifts it left and puts the outcome (1 for taken) into bit 0. That history selects one of 8 counters in the per-branch pattern table.
- R5: A single 3-bit shared history register is shifted left on every resolve, with the outcome entering at bit 0. Its value selects one of 8 counters in the shared pattern table.
- R6: The output is the shared-history guess when the chooser counter of the lookup slot is 2 or 3, and the per-branch guess when it is 0 or 1.
- R7: On a resolve the chooser counter of the resolved slot is incremented (saturating) when only the shared-history guess was correct. It is decremented (saturating) when only the per-branch guess was correct. It is left unchanged when both guesses were correct or both were wrong.
- R8: On a resolve the per-branch counter and the shared counter in use both step one place toward the outcome: up for taken, down for not taken, saturating.
- R9: In a cycle without a resolve, no state changes, and the prediction depends only on the lookup address and the table state.
- R10: A lookup in the same cycle as a resolve returns the prediction from the state before that resolve. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lookupPc | input | 32 | Fetch address to predict |
| predTaken | output | 1 | Prediction for lookupPc, 1 means taken |
| resolveValid | input | 1 | A branch outcome is presented this cycle |
| resolvePc | input | 32 | Address of the resolved branch |
| resolveTaken | input | 1 | Real outcome of the resolved branch, 1 means taken |

## Verification
An always-taken branch drives the counters into saturation and shows that both components agree, so the chooser never moves. A strictly alternating branch can only be learned through its own history, which separates the per-branch path from the shared one. A pair of branches where the second copies a pseudo-random first can only be learned through the shared history, so the chooser is pushed to the shared side. Addresses that alias in bits [4:2], and idle stretches where only the lookup address changes, show that the address is cut down correctly and that state holds when there is no resolve.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Strobes issued by the resolve control to the table datapath
  typedef struct packed {
    logic localUp;
    logic localDn;
    logic globalUp;
    logic globalDn;
    logic chooseGlobal;
    logic chooseLocal;
    logic shiftHist;
  } tpStrobes_t;

endpackage

// File: rtl/tp_control.sv
module tp_control
  import tp_pkg::*;
(
  input  logic       resolveValid,
  input  logic       resolveTaken,
  input  logic       resLocalPred,
  input  logic       resGlobalPred,
  output tpStrobes_t strobes
);

  logic localRight;
  logic globalRight;

  assign localRight  = (resLocalPred == resolveTaken);
  assign globalRight = (resGlobalPred == resolveTaken);

  always_comb begin
    strobes = '0;
    if (resolveValid) begin
      strobes.localUp      = resolveTaken;
      strobes.localDn      = !resolveTaken;
      strobes.globalUp     = resolveTaken;
      strobes.globalDn     = !resolveTaken;
      strobes.chooseGlobal = globalRight && !localRight;
      strobes.chooseLocal  = localRight && !globalRight;
      strobes.shiftHist    = 1'b1;
    end
  end

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 3,
  parameter int LHIST_W = 3,
  parameter int GHIST_W = 3,
  parameter int CNT_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken,
  input  tpStrobes_t      strobes,
  output logic            predTaken,
  output logic            resLocalPred,
  output logic            resGlobalPred
);

  localparam int SLOTS    = 1 << IDX_W;
  localparam int LPAT_N   = 1 << LHIST_W;
  localparam int GPAT_N   = 1 << GHIST_W;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] TAKEN_MIN = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WEAK_NT   = TAKEN_MIN - CNT_W'(1);

  logic [LHIST_W-1:0] localHist [SLOTS];
  logic [CNT_W-1:0]   localCnt  [LPAT_N];
  logic [CNT_W-1:0]   globalCnt [GPAT_N];
  logic [CNT_W-1:0]   chooser   [SLOTS];
  logic [GHIST_W-1:0] ghr;

  logic [IDX_W-1:0] lIdx;
  logic [IDX_W-1:0] rIdx;
  logic unusedPcBits;

  assign lIdx = lookupPc[IDX_W+1:2];
  assign rIdx = resolvePc[IDX_W+1:2];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_W+2], lookupPc[1:0],
                          resolvePc[PC_W-1:IDX_W+2], resolvePc[1:0]};

  function automatic logic [CNT_W-1:0] satStep(input logic [CNT_W-1:0] c,
                                               input logic up, input logic dn);
    if (up && c != CNT_MAX) return c + CNT_W'(1);
    if (dn && c != '0)      return c - CNT_W'(1);
    return c;
  endfunction

  // Lookup side
  logic lookLocal;
  logic lookGlobal;
  assign lookLocal  = localCnt[localHist[lIdx]] >= TAKEN_MIN;
  assign lookGlobal = globalCnt[ghr] >= TAKEN_MIN;
  assign predTaken  = (chooser[lIdx] >= TAKEN_MIN) ? lookGlobal : lookLocal;

  // Resolve side
  logic [LHIST_W-1:0] rHist;
  assign rHist         = localHist[rIdx];
  assign resLocalPred  = localCnt[rHist] >= TAKEN_MIN;
  assign resGlobalPred = globalCnt[ghr] >= TAKEN_MIN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        localHist[i] <= '0;
        chooser[i]   <= WEAK_NT;
      end
      for (int i = 0; i < LPAT_N; i++) localCnt[i]  <= WEAK_NT;
      for (int i = 0; i < GPAT_N; i++) globalCnt[i] <= WEAK_NT;
      ghr <= '0;
    end else begin
      localCnt[rHist] <= satStep(localCnt[rHist], strobes.localUp, strobes.localDn);
      globalCnt[ghr]  <= satStep(globalCnt[ghr], strobes.globalUp, strobes.globalDn);
      chooser[rIdx]   <= satStep(chooser[rIdx], strobes.chooseGlobal, strobes.chooseLocal);
      if (strobes.shiftHist) begin
        localHist[rIdx] <= {rHist[LHIST_W-2:0], resolveTaken};
        ghr             <= {ghr[GHIST_W-2:0], resolveTaken};
      end
    end
  end

  assert_ghr_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.shiftHist) |->
      (ghr[0] == $past(resolveTaken)) && (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));

  assert_ghr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.shiftHist) |-> $stable(ghr));

  assert_chooser_disagree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.chooseGlobal || strobes.chooseLocal) |-> (resLocalPred != resGlobalPred));

  assert_local_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.shiftHist) |-> (localHist[$past(rIdx)][0] == $past(resolveTaken)));

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 3,
  parameter int LHIST_W = 3,
  parameter int GHIST_W = 3,
  parameter int CNT_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            resolveValid,
  input  logic [PC_W-1:0] resolvePc,
  input  logic            resolveTaken
);

  tpStrobes_t strobes;
  logic resLocalPred;
  logic resGlobalPred;

  tp_control u_control (
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .resLocalPred (resLocalPred),
    .resGlobalPred(resGlobalPred),
    .strobes      (strobes)
  );

  tp_datapath #(
    .PC_W(PC_W), .IDX_W(IDX_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W), .CNT_W(CNT_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .lookupPc     (lookupPc),
    .resolvePc    (resolvePc),
    .resolveTaken (resolveTaken),
    .strobes      (strobes),
    .predTaken    (predTaken),
    .resLocalPred (resLocalPred),
    .resGlobalPred(resGlobalPred)
  );

  assert_pred_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!resolveValid) && $stable(lookupPc)) |-> $stable(predTaken));

endmodule

// File: tb/tourney_predictor_bench.sv
module tourney_predictor_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        predTaken;
  logic        resolveValid = 1'b0;
  logic [31:0] resolvePc = '0;
  logic        resolveTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tourney_predictor u_tourney_predictor (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .resolveValid(resolveValid), .resolvePc(resolvePc), .resolveTaken(resolveTaken)
  );

  // Behavioural reference state
  int mHist [8];
  int mLoc  [8];
  int mGlb  [8];
  int mSel  [8];
  int mGhr;

  function automatic int slotOf(input logic [31:0] pc);
    return (pc / 4) % 8;
  endfunction

  function automatic int bump(input int v, input bit up);
    if (up) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  function automatic bit modelPredict(input logic [31:0] pc);
    int s;
    s = slotOf(pc);
    if (mSel[s] >= 2) return mGlb[mGhr] >= 2;
    return mLoc[mHist[s]] >= 2;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin
      mHist[i] = 0; mLoc[i] = 1; mGlb[i] = 1; mSel[i] = 1;
    end
    mGhr = 0;
  endtask

  task automatic modelResolve(input logic [31:0] pc, input bit t);
    int s; bit lOk; bit gOk;
    s = slotOf(pc);
    lOk = ((mLoc[mHist[s]] >= 2) == t);
    gOk = ((mGlb[mGhr] >= 2) == t);
    if (gOk && !lOk) mSel[s] = bump(mSel[s], 1'b1);
    if (lOk && !gOk) mSel[s] = bump(mSel[s], 1'b0);
    mLoc[mHist[s]] = bump(mLoc[mHist[s]], t);
    mGlb[mGhr] = bump(mGlb[mGhr], t);
    mHist[s] = ((mHist[s] * 2) % 8) + int'(t);
    mGhr = ((mGhr * 2) % 8) + int'(t);
  endtask

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive, compare against model, then let the edge update both
  task automatic step(input logic [31:0] lpc, input bit rv, input logic [31:0] rpc,
                      input bit rt, input string tag);
    @(negedge clk);
    lookupPc = lpc; resolveValid = rv; resolvePc = rpc; resolveTaken = rt;
    #1;
    check(tag, predTaken, modelPredict(lpc));
    @(posedge clk);
    if (rv) modelResolve(rpc, rt);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    bit lfsrBit;
    logic [7:0] lfsr;
    bit a;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state predicts not taken everywhere
    for (int i = 0; i < 8; i++) begin
      step(32'h100 + i * 4, 1'b0, '0, 1'b0, "R1 reset model");
      check("R1 reset not taken", predTaken, 1'b0);
    end

    // R3 R8 R10: always-taken branch, lookup same slot in the resolve cycle
    for (int i = 0; i < 10; i++) step(32'h100, 1'b1, 32'h100, 1'b1, "R10 same-cycle lookup");
    step(32'h100, 1'b0, '0, 1'b0, "R3 saturated taken");
    check("R8 trained taken", predTaken, 1'b1);

    // R2: aliasing through bits [4:2]
    step(32'h1120, 1'b0, '0, 1'b0, "R2 alias lookup");
    check("R2 alias equals base", predTaken, 1'b1);
    step(32'h103, 1'b0, '0, 1'b0, "R2 low bits ignored");

    // R4: alternating branch learned by per-branch history
    for (int i = 0; i < 40; i++) step(32'h104, 1'b1, 32'h104, (i % 2) == 0, "R4 alternating");
    for (int i = 0; i < 8; i++)  step(32'h104, 1'b1, 32'h104, (i % 2) == 0, "R4 alternating learned");

    // R5 R6 R7: second branch copies a pseudo-random first
    lfsr = 8'hA5;
    for (int i = 0; i < 120; i++) begin
      lfsrBit = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
      lfsr = {lfsr[6:0], lfsrBit};
      a = lfsr[0];
      step(32'h108, 1'b1, 32'h108, a, "R5 correlated first");
      step(32'h10C, 1'b1, 32'h10C, a, "R6 correlated second");
      step(32'h10C, 1'b0, '0, 1'b0, "R7 chooser idle");
    end

    // R3: drive a slot to not taken saturation
    for (int i = 0; i < 12; i++) step(32'h114, 1'b1, 32'h114, 1'b0, "R3 saturate low");

    // R9: idle, only the lookup address moves
    for (int i = 0; i < 32; i++) step(32'h100 + i * 4, 1'b0, 32'h100 + i * 4, 1'b1, "R9 idle no update");

    // R8: both tables follow a fresh always-taken slot
    for (int i = 0; i < 8; i++) step(32'h118, 1'b1, 32'h118, 1'b1, "R8 train");
    step(32'h118, 1'b0, '0, 1'b0, "R8 trained");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule